// File: doc/BRIEF.md
# Serial Transmitter with Drain-on-Disable

This block sends bytes on an asynchronous serial line. A single-entry holding register sits in front of a frame shifter, so software can queue the next byte while the current one is on the wire. Each frame is 8N1: a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts one period of an external bit-rate tick. Two status flags report the queue state. The empty flag means the holding register can take a byte. The done flag means both the holding register and the shifter are empty. Each flag has its own interrupt mask.

The enable input decides who owns the serial pin. Raising the enable claims the pin and sets both flags. Dropping the enable does not cut the line. A frame already on the wire runs to its stop bit. A byte still waiting in the holding register is thrown away. Both flags are set when that last frame ends, and the pin is handed back to general-purpose I/O on a bit-rate tick. Only the asynchronous reset stops a frame part-way through.

Top module: `uart_tx`

## Requirements
- R1: While reset is asserted and right after it is released, txd_o is 1 and pin_own_o, empty_o, done_o and irq_o are all 0.
- R2: A frame on txd_o is a start bit of 0, then wdata_i[0] through wdata_i[7], then a stop bit of 1. Each bit starts on a cycle with tick_i high and lasts until the next tick. txd_o is 1 whenever the shifter is empty or pin_own_o is 0, and txd_o only changes on the cycle after a tick.
- R3: On a tick where the shifter is idle, or is ending its stop bit, a full holding register moves into the shifter if en_i is 1. Back-to-back frames therefore have no idle bit between them.
- R4: empty_o is cleared by an accepted write. It is set when the holding register moves into the shifter, and it is set on the cycle after en_i goes from 0 to 1.
- R5: done_o is cleared by an accepted write. It is set on the cycle after en_i goes from 0 to 1, and it is set when a stop bit ends with no byte loaded to follow it.
- R6: irq_o equals (empty_ie_i AND empty_o) OR (done_ie_i AND done_o).
- R7: pin_own_o goes to 1 on the cycle after en_i is seen at 1. While en_i is 0, pin_own_o goes to 0 only on a tick where the shifter is idle or is ending its stop bit.
- R8: If en_i drops during a frame, that frame completes. Any byte in the holding register is discarded and never sent. empty_o and done_o are both 1 after the frame's stop bit ends.
- R9: A write with en_i at 0 is ignored. Nothing is queued, and the flags and txd_o do not change because of it.
- R10: Asserting rst_ni during a frame forces txd_o to 1 and pin_own_o to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate tick, one cycle wide |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | 8 | Byte to transmit |
| en_i | input | 1 | Transmit enable |
| empty_ie_i | input | 1 | Interrupt mask for the empty flag |
| done_ie_i | input | 1 | Interrupt mask for the done flag |
| txd_o | output | 1 | Serial data line, idles at 1 |
| pin_own_o | output | 1 | 1 while the transmitter owns the pin |
| empty_o | output | 1 | Holding register can take a byte |
| done_o | output | 1 | Holding register and shifter both empty |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default width of 8 data bits, which gives a 10-bit frame and a 4-bit bit counter. That keeps a whole frame, a queued follow-up byte and a drain after disable inside a few dozen ticks. The tick arrives every fourth cycle in the directed parts and at random spacing in a long random phase. This covers a write landing on the same cycle as a load, and a disable landing on the stop-bit tick. It also covers re-enabling while the last frame is still draining, and writes made while the block is disabled.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {SH_IDLE = 1'b0, SH_BUSY = 1'b1} sh_state_e;

  function automatic int frame_bits(input int data_w);
    return data_w + 2;
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      // disabled: queued byte is dropped, writes ignored
      if (!en_i)      full_q <= 1'b0;
      else if (wr_i)  full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
      if (en_i && wr_i) data_q <= wdata_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              fin_o,
  output logic              free_tick_o,
  output logic              txd_o
);
  localparam int FRAME_W = frame_bits(DATA_W);
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  sh_state_e           st_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                ending, free_tick, load;

  assign ending    = tick_i && (st_q == SH_BUSY) && (cnt_q == LAST);
  assign free_tick = tick_i && ((st_q == SH_IDLE) || (cnt_q == LAST));
  assign load      = free_tick && load_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SH_IDLE;
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load) begin
      st_q  <= SH_BUSY;
      sh_q  <= {1'b1, data_i, 1'b0};
      cnt_q <= '0;
    end else if (ending) begin
      st_q  <= SH_IDLE;
      sh_q  <= '1;
    end else if (tick_i && st_q == SH_BUSY) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign take_o      = load;
  assign fin_o       = ending && !load;
  assign free_tick_o = free_tick;
  assign txd_o       = (st_q == SH_BUSY) ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic take_i,
  input  logic fin_i,
  input  logic free_tick_i,
  input  logic empty_ie_i,
  input  logic done_ie_i,
  output logic pin_own_o,
  output logic empty_o,
  output logic done_o,
  output logic irq_o
);
  logic en_q, pin_q, empty_q, done_q;
  logic empty_d, done_d;

  always_comb begin
    empty_d = empty_q;
    done_d  = done_q;
    if (en_i && !en_q) begin
      empty_d = 1'b1;
      done_d  = 1'b1;
    end
    if (fin_i) begin
      empty_d = 1'b1;
      done_d  = 1'b1;
    end
    if (take_i) empty_d = 1'b1;
    if (wr_i && en_i) begin
      empty_d = 1'b0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pin_q   <= 1'b0;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      en_q    <= en_i;
      empty_q <= empty_d;
      done_q  <= done_d;
      if (en_i)             pin_q <= 1'b1;
      else if (free_tick_i) pin_q <= 1'b0;
    end
  end

  assign pin_own_o = pin_q;
  assign empty_o   = empty_q;
  assign done_o    = done_q;
  assign irq_o     = (empty_ie_i & empty_q) | (done_ie_i & done_q);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              empty_ie_i,
  input  logic              done_ie_i,
  output logic              txd_o,
  output logic              pin_own_o,
  output logic              empty_o,
  output logic              done_o,
  output logic              irq_o
);
  logic              hold_full, take, fin, free_tick, txd_raw;
  logic [DATA_W-1:0] hold_data;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .en_i, .wr_i, .wdata_i,
    .take_i(take), .full_o(hold_full), .data_o(hold_data)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .tick_i,
    .load_req_i(hold_full && en_i), .data_i(hold_data),
    .take_o(take), .fin_o(fin), .free_tick_o(free_tick), .txd_o(txd_raw)
  );

  uart_tx_ctrl u_ctrl (
    .clk_i, .rst_ni, .en_i, .wr_i,
    .take_i(take), .fin_i(fin), .free_tick_i(free_tick),
    .empty_ie_i, .done_ie_i,
    .pin_own_o, .empty_o, .done_o, .irq_o
  );

  assign txd_o = pin_own_o ? txd_raw : 1'b1;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wr_i,
  input logic en_i,
  input logic txd_o,
  input logic pin_own_o,
  input logic empty_o,
  input logic done_o,
  input logic irq_o
);
  // R2
  txd_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(txd_o));
  // R2
  txd_idle_unowned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_own_o |-> txd_o);
  // R4
  empty_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(wr_i && en_i));
  // R5
  done_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(wr_i && en_i));
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (empty_o || done_o));
  // R7
  pin_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_own_o) |-> $past(en_i));
  // R7
  pin_release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_own_o) |-> $past(tick_i && !en_i));
  // R9
  flags_hold_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !tick_i) |=> ($stable(empty_o) && $stable(done_o)));
endmodule

bind uart_tx uart_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .en_i(en_i),
  .txd_o(txd_o), .pin_own_o(pin_own_o), .empty_o(empty_o), .done_o(done_o),
  .irq_o(irq_o)
);

// File: tb/uart_tx_tb.sv
`timescale 1ns/1ps
module uart_tx_tb;
  logic clk = 0, rst_n = 0;
  logic tick_i = 0, wr_i = 0, en_i = 0, eie = 0, die = 0;
  logic [7:0] wdata_i = 0;
  logic txd, pin, empty, done, irq;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit rand_tick = 0, cmp_on = 0;

  always #2.5 clk = ~clk;

  uart_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .en_i(en_i), .empty_ie_i(eie), .done_ie_i(die),
    .txd_o(txd), .pin_own_o(pin), .empty_o(empty), .done_o(done), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] m_hold[$];
  bit   m_enq, m_empty, m_done, m_pin, m_busy;
  int   m_idx;
  logic [7:0] m_byte;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold.delete(); m_enq = 0; m_empty = 0; m_done = 0; m_pin = 0;
      m_busy = 0; m_idx = 0; m_byte = 0;
    end else begin
      bit rise, freet, ending, ld, ne, nd;
      rise   = en_i && !m_enq;
      freet  = tick_i && (!m_busy || m_idx == 9);
      ending = tick_i && m_busy && m_idx == 9;
      ld     = freet && en_i && m_hold.size() != 0;
      ne = m_empty; nd = m_done;
      if (rise) begin ne = 1; nd = 1; end
      if (ending && !ld) begin ne = 1; nd = 1; end
      if (ld) ne = 1;
      if (wr_i && en_i) begin ne = 0; nd = 0; end
      if (ld) begin m_byte = m_hold.pop_front(); m_idx = 0; m_busy = 1; end
      else if (ending) m_busy = 0;
      else if (tick_i && m_busy) m_idx++;
      if (!en_i) m_hold.delete();
      else if (wr_i) begin m_hold.delete(); m_hold.push_back(wdata_i); end
      if (en_i) m_pin = 1; else if (freet) m_pin = 0;
      m_enq = en_i; m_empty = ne; m_done = nd;
    end
  end

  function automatic bit exp_txd();
    if (!m_pin || !m_busy) return 1'b1;
    if (m_idx == 0) return 1'b0;
    if (m_idx == 9) return 1'b1;
    return m_byte[m_idx-1];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    bit ei;
    ei = (eie & m_empty) | (die & m_done);
    check(txd == exp_txd(), "R2/R3 txd", txd, exp_txd());
    check(pin == m_pin, "R7 pin_own", pin, m_pin);
    check(empty == m_empty, "R4 empty", empty, m_empty);
    check(done == m_done, "R5 done", done, m_done);
    check(irq == ei, "R6 irq", irq, ei);
  end

  task automatic step();
    @(posedge clk); #1;
    cyc++;
    wr_i = 0;
    tick_i = rand_tick ? ($urandom_range(0, 2) == 0) : (cyc % 4 == 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(input logic [7:0] b);
    wr_i = 1; wdata_i = b; step();
  endtask

  // wait until a tick is being driven, then return just after it is consumed
  task automatic to_tick();
    while (!tick_i) step();
    step();
  endtask

  initial begin
    #1;
    check(txd == 1 && pin == 0 && empty == 0 && done == 0 && irq == 0,
          "R1 reset", {txd, pin, empty, done, irq}, 5'b10000);
    steps(3);
    rst_n = 1;
    step(); #1;
    check(txd == 1 && pin == 0 && empty == 0 && done == 0,
          "R1 after release", {txd, pin, empty, done}, 4'b1000);
    cmp_on = 1;

    // R4 R5 R7: enable sets flags and claims pin
    en_i = 1; step(); #1;
    check(empty && done && pin, "R4/R5 enable rise", {empty, done, pin}, 3'b111);
    eie = 1; step(); #1;
    check(irq == 1, "R6 masked empty irq", irq, 1);
    eie = 0; die = 0; step(); #1;
    check(irq == 0, "R6 both masks 0", irq, 0);

    // single frame, then two back-to-back (R2, R3)
    write(8'hA5);
    steps(50);
    check(done == 1, "R5 done after frame", done, 1);
    write(8'h3C); to_tick(); write(8'hC3);
    steps(100);
    check(done && empty, "R3 back-to-back drained", {done, empty}, 2'b11);

    // R9: writes while disabled are ignored
    en_i = 0; steps(8);
    check(pin == 0, "R7 idle release", pin, 0);
    write(8'h5A); steps(20);
    check(txd == 1 && empty == 1 && done == 1, "R9 ignored write",
          {txd, empty, done}, 3'b111);

    // R8: disable mid-frame with a queued byte
    en_i = 1; step();
    write(8'h81); to_tick(); write(8'h7E);
    steps(12);
    en_i = 0; step(); #1;
    check(pin == 1, "R8 frame still running", pin, 1);
    steps(60);
    check(done && empty && !pin && txd, "R8 drained and released",
          {done, empty, pin, txd}, 4'b1101);

    // disable exactly at a stop-bit and re-enable while draining
    en_i = 1; step(); write(8'hF0); steps(40); en_i = 0; steps(3); en_i = 1; steps(60);

    // random phase
    rand_tick = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) begin wr_i = 1; wdata_i = 8'($urandom); end
      if ($urandom_range(0, 60) == 0) en_i = ~en_i;
      eie = $urandom_range(0, 1); die = $urandom_range(0, 1);
      step();
    end

    // R10: reset mid-frame
    rand_tick = 0; en_i = 1; step(); write(8'h00); steps(12);
    #1; rst_n = 0; #0.5;
    check(txd == 1 && pin == 0, "R10 async abort", {txd, pin}, 2'b10);
    steps(2); rst_n = 1; steps(4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule